// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns bytes or nine-bit characters into asynchronous serial frames on a single output line. A frame is a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts sixteen pulses of an externally supplied baud tick. The line stays high whenever no frame is being sent.

Software writes a character into a one-entry holding register. The shift register takes the character when it is idle, or on the same clock edge that ends the last stop bit of the frame in progress. A steady writer therefore gets frames with no idle time between them. The ninth data bit comes from its own input and is captured on the same write strobe as the low eight bits.

Two flags report progress. The empty flag follows the holding register. The complete flag marks the moment the line goes idle with nothing left to send. Each flag drives an interrupt request through its own enable.

Top module: `uart_dbuf_tx`

## Requirements
- R1: `tx_o` is 1 while no frame is active and while `tx_en` is 0. Dropping `tx_en` abandons the frame in progress, but a character waiting in the holding register is kept.
- R2: Each frame bit is held on `tx_o` for 16 `baud_tick` pulses, counted from the clock edge at which the frame was loaded.
- R3: A frame is sent in this order: a 0 start bit, the data bits with the least significant bit first, the parity bit when `cfg_par_en` is 1, then one 1 stop bit, or two when `cfg_two_stop` is 1. `cfg_size` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits; any value of 4 or more selects 9 data bits.
- R4: The parity bit is the XOR of the data bits in use. It is inverted when `cfg_par_odd` is 1.
- R5: A waiting character is loaded when the shift register is idle, or on the edge that ends the final stop bit of the current frame. Back-to-back frames have no idle cycles between them.
- R6: Data bit 8 is the value of `tx_bit8` sampled on the clock edge where `wr_en` is 1. Later changes to `tx_bit8` do not affect that character.
- R7: `dre_flag` is 1 exactly when the holding register is empty. It is 1 after reset. `dre_irq` equals `dre_flag` AND `dre_ie`.
- R8: `txc_flag` becomes 1 on the edge that ends a final stop bit when no character is loaded on that edge. It becomes 0 on an edge where `txc_clr` or `txc_ack` is 1. If a set and a clear fall on the same edge, the set wins. `txc_irq` equals `txc_flag` AND `txc_ie`.
- R9: A write while the holding register is full, and not being loaded on that edge, replaces the waiting character and sets `ovr_err`. `ovr_err` stays 1 until an edge with `ovr_clr` at 1 and no new overwrite.
- R10: The `cfg_*` inputs are sampled only on the edge that loads a frame. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_en | input | 1 | Transmitter enable |
| cfg_size | input | 3 | Data length select (0..3 for 5..8 bits, 4 or more for 9 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Data bits 7..0 |
| tx_bit8 | input | 1 | Data bit 8, captured with `wr_en` |
| txc_clr | input | 1 | Write-one-to-clear for `txc_flag` |
| txc_ack | input | 1 | Interrupt acknowledge for `txc_flag` |
| ovr_clr | input | 1 | Clears `ovr_err` |
| dre_ie | input | 1 | Interrupt enable for the empty flag |
| txc_ie | input | 1 | Interrupt enable for the complete flag |
| tx_o | output | 1 | Serial output line |
| dre_flag | output | 1 | Holding register empty |
| txc_flag | output | 1 | Transmission complete |
| ovr_err | output | 1 | Sticky overwrite error |
| dre_irq | output | 1 | Empty interrupt request |
| txc_irq | output | 1 | Complete interrupt request |

## Verification
The hardest case to reach is the edge that ends a frame's last stop bit on the same clock edge that loads the next character. That is where the zero-gap handoff, the suppression of `txc_flag`, and an overwrite racing the load all meet. The stimulus reaches it by waiting for `dre_flag` to return to 1 after the first load, then writing the second character straight away, so that it is waiting when the first frame ends. A further write is placed while the second character is still pending, and the format inputs are changed partway through a frame. A behavioural model built on a bit queue predicts every output on every cycle, so a handoff that is one cycle early or late shows up as a mismatch on the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int unsigned MAX_DATA = 9;
  localparam int unsigned FRAME_W  = 1 + MAX_DATA + 1 + 2;
  localparam int unsigned LEN_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [2:0] size;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } tx_cfg_t;

  function automatic int unsigned data_len(input logic [2:0] size);
    if (size >= 3'd4) return MAX_DATA;
    return 5 + int'(size);
  endfunction

  function automatic logic calc_parity(input logic [MAX_DATA-1:0] d,
                                       input logic [2:0] size,
                                       input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < int'(data_len(size))) p = p ^ d[i];
    end
    return p;
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic [MAX_DATA-1:0] d,
                                                     input tx_cfg_t cfg);
    logic [FRAME_W-1:0] f;
    int unsigned        n;
    n = data_len(cfg.size);
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < int'(n)) f[1+i] = d[i];
    end
    for (int j = 1; j < FRAME_W; j++) begin
      if (cfg.par_en && (j == int'(n) + 1)) f[j] = calc_parity(d, cfg.size, cfg.par_odd);
    end
    return f;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input tx_cfg_t cfg);
    int unsigned l;
    l = 1 + data_len(cfg.size) + (cfg.par_en ? 1 : 0) + (cfg.two_stop ? 2 : 1);
    return LEN_W'(l);
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  input  logic         ovr_clr,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         ovr_err
);

  logic overwrite;
  assign overwrite = wr_en & valid & ~take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      data    <= '0;
      ovr_err <= 1'b0;
    end else begin
      if (wr_en) begin
        data  <= wr_data;
        valid <= 1'b1;
      end else if (take) begin
        valid <= 1'b0;
      end
      if (overwrite)    ovr_err <= 1'b1;
      else if (ovr_clr) ovr_err <= 1'b0;
    end
  end

  AST_TAKE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> valid); // R5

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !ovr_clr) |=> ovr_err); // R9

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && valid && !take) |=> ovr_err); // R9

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               baud_tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [LEN_W-1:0]   len_in,
  output logic               ser_o,
  output logic               active,
  output logic               frame_done
);

  localparam int unsigned TCW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [TCW-1:0] TLAST = TCW'(OVERSAMPLE - 1);

  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   remain;
  logic [TCW-1:0]     tcnt;
  logic               bit_end;

  assign bit_end    = enable & active & baud_tick & (tcnt == TLAST);
  assign frame_done = bit_end & (remain == LEN_W'(1));
  assign ser_o      = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '1;
      remain <= '0;
      tcnt   <= '0;
      active <= 1'b0;
    end else if (!enable) begin
      shreg  <= '1;
      remain <= '0;
      tcnt   <= '0;
      active <= 1'b0;
    end else if (load) begin
      shreg  <= frame_in;
      remain <= len_in;
      tcnt   <= '0;
      active <= 1'b1;
    end else if (bit_end) begin
      shreg  <= {1'b1, shreg[FRAME_W-1:1]};
      remain <= remain - LEN_W'(1);
      tcnt   <= '0;
      if (remain == LEN_W'(1)) active <= 1'b0;
    end else if (active && baud_tick) begin
      tcnt <= tcnt + TCW'(1);
    end
  end

  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && load) |=> !ser_o); // R3

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && active && !baud_tick && !load) |=> $stable(ser_o)); // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !load) |=> !active); // R5

endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic load,
  input  logic hold_valid,
  input  logic txc_clr,
  input  logic txc_ack,
  input  logic dre_ie,
  input  logic txc_ie,
  output logic dre_flag,
  output logic txc_flag,
  output logic dre_irq,
  output logic txc_irq
);

  logic txc_set;
  assign txc_set = frame_done & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   txc_flag <= 1'b0;
    else if (txc_set)             txc_flag <= 1'b1;
    else if (txc_clr || txc_ack)  txc_flag <= 1'b0;
  end

  assign dre_flag = ~hold_valid;
  assign dre_irq  = dre_flag & dre_ie;
  assign txc_irq  = txc_flag & txc_ie;

  AST_TXC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !load) |=> txc_flag); // R8

  AST_TXC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((txc_clr || txc_ack) && !(frame_done && !load)) |=> !txc_flag); // R8

  AST_TXC_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!txc_flag && frame_done && load) |=> !txc_flag); // R5

endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       tx_en,
  input  logic [2:0] cfg_size,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       tx_bit8,
  input  logic       txc_clr,
  input  logic       txc_ack,
  input  logic       ovr_clr,
  input  logic       dre_ie,
  input  logic       txc_ie,
  output logic       tx_o,
  output logic       dre_flag,
  output logic       txc_flag,
  output logic       ovr_err,
  output logic       dre_irq,
  output logic       txc_irq
);

  tx_cfg_t             cfg;
  logic                hold_valid;
  logic [MAX_DATA-1:0] hold_data;
  logic                sh_active;
  logic                sh_done;
  logic                sh_ser;
  logic                load;
  logic [FRAME_W-1:0]  next_frame;
  logic [LEN_W-1:0]    next_len;

  assign cfg = '{size: cfg_size, par_en: cfg_par_en,
                 par_odd: cfg_par_odd, two_stop: cfg_two_stop};

  assign load       = tx_en & hold_valid & (~sh_active | sh_done);
  assign next_frame = build_frame(hold_data, cfg);
  assign next_len   = frame_len(cfg);

  uart_tx_hold #(.W(MAX_DATA)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data ({tx_bit8, wr_data}),
    .take    (load),
    .ovr_clr (ovr_clr),
    .valid   (hold_valid),
    .data    (hold_data),
    .ovr_err (ovr_err)
  );

  uart_tx_shift #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (tx_en),
    .baud_tick  (baud_tick),
    .load       (load),
    .frame_in   (next_frame),
    .len_in     (next_len),
    .ser_o      (sh_ser),
    .active     (sh_active),
    .frame_done (sh_done)
  );

  uart_tx_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (sh_done),
    .load       (load),
    .hold_valid (hold_valid),
    .txc_clr    (txc_clr),
    .txc_ack    (txc_ack),
    .dre_ie     (dre_ie),
    .txc_ie     (txc_ie),
    .dre_flag   (dre_flag),
    .txc_flag   (txc_flag),
    .dre_irq    (dre_irq),
    .txc_irq    (txc_irq)
  );

  assign tx_o = tx_en ? sh_ser : 1'b1;

  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_active |-> tx_o); // R1

  AST_EMPTY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_en) |=> dre_flag); // R7

  AST_FULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !dre_flag); // R7

endmodule

// File: tb/uart_dbuf_tx_tb.sv
module uart_dbuf_tx_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic en = 1'b0;
  logic [2:0] size = 3'd3;
  logic pen = 1'b0, podd = 1'b0, two = 1'b0;
  logic wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic b8 = 1'b0;
  logic tclr = 1'b0, tack = 1'b0, oclr = 1'b0, die = 1'b0, tie = 1'b0;
  logic tx, dre, txc, ovr, dirq, tirq;

  always #2 clk = ~clk;

  uart_dbuf_tx u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(tick), .tx_en(en),
    .cfg_size(size), .cfg_par_en(pen), .cfg_par_odd(podd), .cfg_two_stop(two),
    .wr_en(wr), .wr_data(wdata), .tx_bit8(b8),
    .txc_clr(tclr), .txc_ack(tack), .ovr_clr(oclr), .dre_ie(die), .txc_ie(tie),
    .tx_o(tx), .dre_flag(dre), .txc_flag(txc), .ovr_err(ovr),
    .dre_irq(dirq), .txc_irq(tirq)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  string scen = "R1 reset";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  bit m_full, m_busy, m_txc, m_ovr, m_done, m_ld, m_was_busy;
  int m_hold, m_ticks, m_n, m_ones;
  int m_q[$];

  int tdiv = 0;
  always @(negedge clk) begin
    tick <= (tdiv == 0);
    tdiv = (tdiv + 1) % 2;
  end

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_full = 0; m_busy = 0; m_txc = 0; m_ovr = 0; m_ticks = 0; m_q.delete();
    end else begin
      m_was_busy = m_busy;
      m_done = 0;
      if (!en) begin
        m_busy = 0; m_q.delete(); m_ticks = 0;
      end else if (m_busy && tick) begin
        if (m_ticks == 15) begin
          m_ticks = 0;
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin m_busy = 0; m_done = 1; end
        end else m_ticks++;
      end
      m_ld = en && m_full && (!m_was_busy || m_done);
      if (m_ld) begin
        m_n = (size >= 4) ? 9 : 5 + int'(size);
        m_q.delete();
        m_q.push_back(0);
        m_ones = 0;
        for (int i = 0; i < m_n; i++) begin
          m_q.push_back((m_hold >> i) & 1);
          m_ones += (m_hold >> i) & 1;
        end
        if (pen) m_q.push_back((m_ones % 2) ^ int'(podd));
        m_q.push_back(1);
        if (two) m_q.push_back(1);
        m_busy = 1; m_ticks = 0;
      end
      if (m_done && !m_ld) m_txc = 1;
      else if (tclr || tack) m_txc = 0;
      if (wr && m_full && !m_ld) m_ovr = 1;
      else if (oclr) m_ovr = 0;
      if (wr) begin m_full = 1; m_hold = {b8, wdata}; end
      else if (m_ld) m_full = 0;
    end
    #1;
    if (rst_n) begin
      chk(tx === ((en && m_busy) ? m_q[0][0] : 1'b1), scen, int'(tx), (en && m_busy) ? m_q[0] : 1);
      chk(dre === !m_full, "R7 dre_flag", int'(dre), int'(!m_full));
      chk(dirq === (!m_full && die), "R7 dre_irq", int'(dirq), int'(!m_full && die));
      chk(txc === m_txc, "R8 txc_flag", int'(txc), int'(m_txc));
      chk(tirq === (m_txc && tie), "R8 txc_irq", int'(tirq), int'(m_txc && tie));
      chk(ovr === m_ovr, "R9 ovr_err", int'(ovr), int'(m_ovr));
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic put(input logic [8:0] d);
    @(negedge clk);
    wr = 1'b1; wdata = d[7:0]; b8 = d[8];
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse_clr(input int which);
    @(negedge clk);
    if (which == 0) tclr = 1'b1; else if (which == 1) tack = 1'b1; else oclr = 1'b1;
    @(negedge clk);
    tclr = 1'b0; tack = 1'b0; oclr = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy || m_full);
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg(input int s, input bit pe, input bit po, input bit ts);
    @(negedge clk);
    size = 3'(s); pen = pe; podd = po; two = ts;
  endtask

  int lowlen;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 R7 R8 R9: reset state
    chk(tx === 1'b1, "R1 reset line", int'(tx), 1);
    chk(dre === 1'b1, "R7 reset empty", int'(dre), 1);
    chk(txc === 1'b0 && ovr === 1'b0, "R8 R9 reset flags", int'({txc, ovr}), 0);
    en = 1'b1; die = 1'b1; tie = 1'b1;

    // R2 R3: 8 data bits, start bit length
    scen = "R3 8N1";
    cfg(3, 0, 0, 0);
    put(9'h0FF);
    do @(negedge clk); while (tx !== 1'b0);
    lowlen = 0;
    while (tx === 1'b0) begin lowlen++; @(negedge clk); end
    chk(lowlen >= 31 && lowlen <= 32, "R2 start bit length", lowlen, 32);
    wait_idle();
    chk(txc === 1'b1, "R8 set after frame", int'(txc), 1);
    pulse_clr(0);
    #1 chk(txc === 1'b0, "R8 write-one clear", int'(txc), 0);

    // R3 R4: 5 bits even parity two stops
    scen = "R4 5E2";
    cfg(0, 1, 0, 1);
    put(9'h0B6);
    wait_idle();
    pulse_clr(1);
    #1 chk(txc === 1'b0, "R8 ack clear", int'(txc), 0);

    // R4: 7 bits odd parity
    scen = "R4 7O1";
    cfg(2, 1, 1, 0);
    put(9'h05A);
    wait_idle();

    // R6: nine bits, bit8 changed after the write
    scen = "R6 9O1";
    cfg(4, 1, 1, 0);
    put(9'h155);
    b8 = 1'b0;
    wait_idle();
    scen = "R3 size 6 means 9 bits";
    cfg(6, 0, 0, 1);
    put(9'h1C3);
    wait_idle();

    // R5: back-to-back with no gap, plus R9 overwrite
    scen = "R5 back-to-back";
    pulse_clr(0);
    cfg(1, 0, 0, 0);
    put(9'h021);
    do @(negedge clk); while (!dre);
    put(9'h012);
    put(9'h03C);
    #1 chk(ovr === 1'b1, "R9 overwrite flagged", int'(ovr), 1);
    do @(negedge clk); while (m_full);
    #1 chk(txc === 1'b0, "R5 no complete at handoff", int'(txc), 0);
    wait_idle();
    pulse_clr(2);
    #1 chk(ovr === 1'b0, "R9 clear", int'(ovr), 0);

    // R10: config changed mid-frame
    scen = "R10 cfg mid-frame";
    cfg(3, 1, 0, 0);
    put(9'h0C9);
    repeat (60) @(negedge clk);
    size = 3'd0; pen = 1'b0; two = 1'b1;
    wait_idle();

    // R1: disable mid-frame, pending data survives
    scen = "R1 disable mid-frame";
    cfg(3, 0, 0, 0);
    put(9'h0AA);
    put(9'h055);
    repeat (40) @(negedge clk);
    en = 1'b0;
    repeat (50) @(negedge clk);
    #1 chk(tx === 1'b1 && dre === 1'b0, "R1 released, data kept", int'({tx, dre}), 2);
    @(negedge clk);
    en = 1'b1;
    wait_idle();

    // R7 R8: interrupt enables off
    scen = "R7 irq masked";
    die = 1'b0; tie = 1'b0;
    put(9'h011);
    wait_idle();
    #1 chk(tirq === 1'b0 && dirq === 1'b0, "R8 R7 masked irqs", int'({tirq, dirq}), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule